// File: doc/BRIEF.md
# Static Schedule State Sequencer

This block steps a statically scheduled region through a fixed ring of states, one state per clock cycle unless told to wait. It drives one active flag per state, and the surrounding datapath uses those flags to enable the work of each cycle. Every state's outgoing edge is set by parameters. A state either falls through to the next index, jumps to a fixed target, or walks an ordered list of guarded targets chosen from a vector of external guard bits.

State 0 does two jobs. It is the resting state and also the first working state. While it is not being started it holds still with no flag raised. Any edge out of it needs the start input. One chosen state can own a latency counter that counts up to a fixed operation latency. It holds the sequencer in that state until the count completes.

The whole configuration is given as flat parameter vectors, one field per state. State s sits at bit offset s times the field width. In the guarded-target vectors, entry s*ARMS+a is arm a of state s.

Top module: `sfsm_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in state 0 and clears the latency counter. After reset, with start low, every active flag is low.
- R2: For a state i greater than 0, flag i is high exactly while the sequencer is in state i. Flag 0 is high only while the sequencer is in state 0 and start is high. At most one flag is high at any time.
- R3: State 0 leaves only on a clock edge where start is high. With start low it stays in state 0 whatever its configured exit is. With start high it takes its configured exit, which for kind 0 is state 1.
- R4: A state of kind 0 moves to the next index on the following edge. The last state, N-1, moves to state 0.
- R5: A state of kind 1 moves to its configured jump target on the following edge, whatever the guards are.
- R6: A state of kind 2 checks its first ARM_CNT arms in order, arm 0 first. It moves to the target of the first arm whose guard is true. An arm's guard is guard bit k when its select value k is below NUM_GUARDS; a select value equal to NUM_GUARDS means always true.
- R7: When no arm of a kind-2 state is true, the sequencer stays in that state. A list whose last used arm is always true never stays in its state.
- R8: The latency counter is ceil(log2(L+1)) bits wide. It advances only while its owning state's flag is high and holds otherwise. It goes back to 0 after reaching L-1.
- R9: The counter-owning state leaves only on an edge where the counter equals L-1. This condition is added to its other exit conditions. Entered fresh, with its exit otherwise open, it is active for exactly L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request; gates state 0's flag and its exit |
| guard_i | input | NUM_GUARDS | Guard bits selected by conditional arms |
| active_o | output | NUM_STATES | One flag per state |

## Verification
The bench builds six states and four guard bits, with at most two arms per state. State 0 and state 5 fall through. State 1 holds a two-arm list with no always-true arm, so both arm priority and the implicit self-loop can be reached. State 2 jumps to state 5. State 3 owns a latency counter with L = 3, so the bench can see a dwell of three cycles on each entry and the counter coming back aligned. State 4 ends its list with an always-true arm, which shows that a guarded first arm wins over the fallback and that the fallback leaves no self-loop.

// File: rtl/sfsm_pkg.sv
package sfsm_pkg;
   // Transition kind of one state, 2 bits per state in the kind vector.
   typedef enum logic [1:0] {
      STEP_NEXT = 2'd0,
      STEP_JUMP = 2'd1,
      STEP_COND = 2'd2
   } step_kind_e;
endpackage

// File: rtl/sfsm_state_next.sv
module sfsm_state_next
   import sfsm_pkg::*;
#(
   parameter int NUM_STATES = 6,
   parameter int NUM_GUARDS = 4,
   parameter int ARMS       = 2,
   parameter int STATE_IDX  = 0,
   parameter int SW         = 3,
   parameter int GW         = 3,
   parameter int ACW        = 2,
   parameter logic [1:0]         KIND     = 2'd0,
   parameter logic [SW-1:0]      JUMP_TGT = '0,
   parameter logic [ACW-1:0]     ARM_CNT  = '0,
   parameter logic [ARMS*SW-1:0] ARM_TGT  = '0,
   parameter logic [ARMS*GW-1:0] ARM_SEL  = '0
) (
   input  logic [NUM_GUARDS-1:0] guard_i,
   output logic [SW-1:0]         nxt_o
);
   localparam logic [SW-1:0] SELF = SW'(STATE_IDX);
   localparam logic [SW-1:0] SUCC = (STATE_IDX == NUM_STATES-1) ? '0 : SW'(STATE_IDX+1);

   if (KIND == STEP_NEXT) begin : g_next
      assign nxt_o = SUCC;
   end else if (KIND == STEP_JUMP) begin : g_jump
      if (int'(JUMP_TGT) >= NUM_STATES) begin : g_bad_jump
         $error("jump target out of range");
      end
      assign nxt_o = JUMP_TGT;
   end else if (KIND == STEP_COND) begin : g_cond
      logic [ARMS-1:0] hit;
      if (int'(ARM_CNT) > ARMS) begin : g_bad_cnt
         $error("arm count exceeds ARMS");
      end
      for (genvar a = 0; a < ARMS; a++) begin : g_arm
         localparam int SEL = int'(ARM_SEL[a*GW +: GW]);
         if (a >= int'(ARM_CNT)) begin : g_unused
            assign hit[a] = 1'b0;
         end else begin : g_used
            if (int'(ARM_TGT[a*SW +: SW]) >= NUM_STATES) begin : g_bad_tgt
               $error("arm target out of range");
            end
            if (SEL >= NUM_GUARDS) begin : g_always
               assign hit[a] = 1'b1;
            end else begin : g_guard
               assign hit[a] = guard_i[SEL];
            end
         end
      end
      // Walk from the last arm down so the lowest true arm is kept;
      // no true arm leaves the state on itself.
      always_comb begin
         nxt_o = SELF;
         for (int a = ARMS-1; a >= 0; a--) begin
            if (hit[a]) nxt_o = ARM_TGT[a*SW +: SW];
         end
      end
   end else begin : g_bad_kind
      $error("unknown transition kind");
      assign nxt_o = SELF;
   end
endmodule

// File: rtl/sfsm_lat_counter.sv
module sfsm_lat_counter #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic en_i,
   output logic done_o
);
   localparam int CW = $clog2(LAT+1);
   localparam logic [CW-1:0] LAST = CW'(LAT-1);

   if (LAT < 1) begin : g_bad_lat
      $error("latency must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
   end

   assign done_o = (cnt_q == LAST);

   assert_cnt_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (en_i && done_o) |=> (cnt_q == '0));
   assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!en_i) |=> $stable(cnt_q));
   assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);
endmodule

// File: rtl/sfsm_seq.sv
module sfsm_seq
   import sfsm_pkg::*;
#(
   parameter int NUM_STATES = 6,
   parameter int NUM_GUARDS = 4,
   parameter int ARMS       = 2,
   parameter int SW         = $clog2(NUM_STATES),
   parameter int GW         = $clog2(NUM_GUARDS+1),
   parameter int ACW        = $clog2(ARMS+1),
   parameter logic [NUM_STATES*2-1:0]       KIND_VEC = {2'd0,2'd2,2'd0,2'd1,2'd2,2'd0},
   parameter logic [NUM_STATES*SW-1:0]      JUMP_VEC = {3'd0,3'd0,3'd0,3'd5,3'd0,3'd0},
   parameter logic [NUM_STATES*ACW-1:0]     ACNT_VEC = {2'd0,2'd2,2'd0,2'd0,2'd2,2'd0},
   parameter logic [NUM_STATES*ARMS*SW-1:0] ATGT_VEC = {3'd0,3'd0, 3'd5,3'd0, 3'd0,3'd0,
                                                         3'd0,3'd0, 3'd2,3'd3, 3'd0,3'd0},
   parameter logic [NUM_STATES*ARMS*GW-1:0] ASEL_VEC = {3'd0,3'd0, 3'd4,3'd2, 3'd0,3'd0,
                                                         3'd0,3'd0, 3'd1,3'd0, 3'd0,3'd0},
   parameter bit CNT_EN    = 1'b1,
   parameter int CNT_STATE = 3,
   parameter int CNT_LAT   = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start_i,
   input  logic [NUM_GUARDS-1:0] guard_i,
   output logic [NUM_STATES-1:0] active_o
);
   if (NUM_STATES < 2) begin : g_bad_n
      $error("need at least two states");
   end
   if (CNT_EN && (CNT_STATE < 0 || CNT_STATE >= NUM_STATES)) begin : g_bad_cs
      $error("counter state out of range");
   end

   logic [SW-1:0] cur_q, nxt, cand;
   logic [SW-1:0] cand_arr [NUM_STATES];
   logic          cnt_done, exit_ok;

   // Per-state candidate successor, each built from its own slice.
   for (genvar s = 0; s < NUM_STATES; s++) begin : g_st
      sfsm_state_next #(
         .NUM_STATES(NUM_STATES), .NUM_GUARDS(NUM_GUARDS), .ARMS(ARMS),
         .STATE_IDX(s), .SW(SW), .GW(GW), .ACW(ACW),
         .KIND    (KIND_VEC[s*2 +: 2]),
         .JUMP_TGT(JUMP_VEC[s*SW +: SW]),
         .ARM_CNT (ACNT_VEC[s*ACW +: ACW]),
         .ARM_TGT (ATGT_VEC[s*ARMS*SW +: ARMS*SW]),
         .ARM_SEL (ASEL_VEC[s*ARMS*GW +: ARMS*GW])
      ) u_next (
         .guard_i(guard_i),
         .nxt_o  (cand_arr[s])
      );
      assign active_o[s] = (cur_q == SW'(s)) && (s != 0 || start_i);
   end

   always_comb begin
      cand = '0;
      for (int s = 0; s < NUM_STATES; s++) begin
         if (cur_q == SW'(s)) cand = cand_arr[s];
      end
   end

   if (CNT_EN) begin : g_cnt
      sfsm_lat_counter #(.LAT(CNT_LAT)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .en_i  (active_o[CNT_STATE]),
         .done_o(cnt_done)
      );
   end else begin : g_nocnt
      assign cnt_done = 1'b1;
   end

   // A closed gate makes every arm false, which leaves the state on itself.
   always_comb begin
      exit_ok = 1'b1;
      if (cur_q == '0 && !start_i) exit_ok = 1'b0;
      if (CNT_EN && cur_q == SW'(CNT_STATE) && !cnt_done) exit_ok = 1'b0;
   end
   assign nxt = exit_ok ? cand : cur_q;

   always_ff @(posedge clk) begin
      if (rst) cur_q <= '0;
      else     cur_q <= nxt;
   end

   assert_onehot_flags_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(active_o));
   assert_state_range_R1: assert property (@(posedge clk) disable iff (rst)
      int'(cur_q) < NUM_STATES);
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (cur_q == '0 && !start_i) |=> (cur_q == '0));

   if (KIND_VEC[(NUM_STATES-1)*2 +: 2] == STEP_NEXT &&
       !(CNT_EN && CNT_STATE == NUM_STATES-1)) begin : g_wrap_chk
      assert_last_wrap_R4: assert property (@(posedge clk) disable iff (rst)
         (cur_q == SW'(NUM_STATES-1)) |=> (cur_q == '0));
   end

   if (CNT_EN) begin : g_dwell_chk
      assert_dwell_hold_R9: assert property (@(posedge clk) disable iff (rst)
         (cur_q == SW'(CNT_STATE) && !cnt_done && (CNT_STATE != 0 || start_i))
         |=> (cur_q == SW'(CNT_STATE)));
   end
endmodule

// File: tb/sfsm_seq_test.sv
`timescale 1ns/1ps
module sfsm_seq_test;
   localparam int N = 6;
   localparam int G = 4;

   typedef struct {
      logic [N-1:0] exp;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_i = 1'b0;
   logic [G-1:0] guard_i = '0;
   logic [N-1:0] active_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   item_t sb [$];

   always #2.5 clk = ~clk;

   sfsm_seq uut (
      .clk(clk), .rst(rst), .start_i(start_i),
      .guard_i(guard_i), .active_o(active_o)
   );

   // Driver: set inputs for one cycle and queue the flags expected in it.
   task automatic cyc(input logic st, input logic [G-1:0] g, input int e, input string tag);
      item_t it;
      @(negedge clk);
      start_i = st;
      guard_i = g;
      it.exp  = (e == 0 && !st) ? '0 : (N'(1) << e);
      it.tag  = tag;
      sb.push_back(it);
   endtask

   // Monitor: compare shortly after the falling edge, away from the rising edge.
   always @(negedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (active_o !== it.exp) begin
            errors++;
            $display("FAIL %s: active_o=%b expected %b", it.tag, active_o, it.exp);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      cyc(0, 4'b0000, 0, "R1 idle after reset");
      cyc(0, 4'b1111, 0, "R3 hold without start");
      cyc(1, 4'b0000, 0, "R3 start raises flag 0");
      cyc(0, 4'b0000, 1, "R2 state 1 flag");
      cyc(0, 4'b0100, 1, "R7 no arm true, self-loop");
      cyc(0, 4'b0011, 1, "R6 both arms true");
      cyc(0, 4'b0000, 3, "R6 arm 0 won; R8 count 0");
      cyc(1, 4'b1111, 3, "R9 dwell count 1");
      cyc(0, 4'b0000, 3, "R9 dwell count 2");
      cyc(0, 4'b0000, 4, "R9 exit after L cycles");
      cyc(0, 4'b0000, 5, "R7 always arm taken");
      cyc(0, 4'b0000, 0, "R4 last wraps to 0");
      cyc(0, 4'b0000, 0, "R3 idle again");
      cyc(1, 4'b0000, 0, "R3 start again");
      cyc(0, 4'b0010, 1, "R6 arm 1 only");
      cyc(0, 4'b0000, 2, "R6 arm 1 target");
      cyc(1, 4'b1111, 5, "R5 jump to 5");
      cyc(1, 4'b0000, 0, "R4 wrap with start high");
      cyc(1, 4'b0001, 1, "R4 state 0 kind 0 goes to 1");
      cyc(1, 4'b0001, 3, "R8 counter aligned on re-entry");
      cyc(0, 4'b0000, 3, "R9 second dwell 1");
      cyc(0, 4'b0000, 3, "R9 second dwell 2");
      cyc(0, 4'b0100, 4, "R9 second exit");
      cyc(0, 4'b0000, 0, "R6 guarded arm beats always arm");
      cyc(1, 4'b0000, 0, "R3 start");
      cyc(0, 4'b0000, 1, "R2 in state 1 before reset");
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      cyc(0, 4'b0011, 0, "R1 reset mid-run returns to 0");
      cyc(0, 4'b0000, 0, "R1 still idle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule